// File: doc/BRIEF.md
# Masked Bit-Serial SIMON128/128 Encryption Datapath

This block encrypts one 128-bit block with SIMON128/128 while every bit of the state is held as two Boolean shares. A share pair (a, b) stands for the value a XOR b. Neither share alone is the plaintext, the state or the ciphertext. The datapath processes one bit of both shares per clock cycle. Share generation happens outside the block, and so does recombination of the result. The round-key schedule is also outside: a neighbouring block streams the two key-share bits and one fresh random bit on every round cycle.

A start pulse in the idle state opens a 128-cycle serial load of both plaintext shares. Then come 68 rounds of 64 cycles each. Each cycle produces one new bit of the left word for both shares. A two-share masked AND combines the two shares of the rotated operands, and the random bit is injected there. Two 8-bit window registers per share alternate between two jobs. One supplies the rotated neighbour bits of the word being consumed. The other collects the top bits of the word being produced. Two 64-bit bit FIFOs per share hold the two Feistel halves. After the last round, the two ciphertext shares are streamed out for 128 cycles, and a done pulse follows.

Top module: `masked_simon_serial`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, key_take, ct_vld and done are all low.
- R2: A start pulse in idle leads to 128 load cycles. After them, key_take is high for exactly 68 x 64 = 4352 consecutive cycles. In each of those cycles one key-share bit per share is consumed. Round keys arrive round 0 first, each least significant bit first.
- R3: Plaintext shares enter as 128-bit words least significant bit first. Stream bits 0..63 form the right word y and bits 64..127 form the left word x.
- R4: The XOR of the two output share streams equals the SIMON128/128 encryption of (pa XOR pb) under the round keys (ka XOR kb). This covers the published vector: key 0f0e0d0c0b0a09080706050403020100 and plaintext 63736564207372656c6c657661727420 encrypt to 49681b1e1e54fe3f65aa832af84e0bbc.
- R5: Once the last round has finished, ct_vld is high for exactly 128 consecutive cycles. During them, ct_a and ct_b carry the ciphertext shares least significant bit first, with the right word first. ct_vld never overlaps key_take.
- R6: done is a single-cycle pulse in the cycle right after the last ct_vld cycle.
- R7: start is ignored while loading, running or unloading. Neither the result nor the cycle counts change.
- R8: With zero plaintext mask, zero key mask and an all-zero random stream, ct_b is all zero and ct_a equals the ciphertext.
- R9: The recombined result does not depend on the random bit stream or on the mask values.
- R10: After done, a new start begins a fresh encryption with no leftover state, and so does a reset applied mid-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| start | input | 1 | Begin a load; honoured only while idle |
| pa_bit | input | 1 | Plaintext share a, serial, during load |
| pb_bit | input | 1 | Plaintext share b, serial, during load |
| ka_bit | input | 1 | Round-key share a bit, consumed when key_take is high |
| kb_bit | input | 1 | Round-key share b bit, consumed when key_take is high |
| rnd_bit | input | 1 | Fresh random bit for the masked AND, consumed when key_take is high |
| key_take | output | 1 | High in every round cycle |
| ct_a | output | 1 | Ciphertext share a bit, valid with ct_vld |
| ct_b | output | 1 | Ciphertext share b bit, valid with ct_vld |
| ct_vld | output | 1 | Ciphertext bits are being presented |
| done | output | 1 | One-cycle pulse after the final output bit |

## Verification
The bench looks at the round boundaries, where the two windows trade roles. If the swap were off by one round, or if a window were left unloaded at the start, the wrap-around bits x[63], x[62] and x[56] would be wrong for the first eight bits of a round. No vector would then match the reference model, the published one included. Masked runs with different random streams and masks, on the same key and plaintext, expose a cross-term missing from the masked AND: that error cancels only when the masks are zero. The zero-mask run catches the opposite fault, a share b that picks up share a terms. Starts poked in mid-run and in mid-unload, along with exact counts of key and output cycles and a reset during the rounds, catch a controller that restarts early or drops a cycle.

// File: rtl/masked_simon_serial.sv
module masked_simon_serial #(
  parameter int WORD   = 64,
  parameter int ROUNDS = 68
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pa_bit,
  input  logic pb_bit,
  input  logic ka_bit,
  input  logic kb_bit,
  input  logic rnd_bit,
  output logic key_take,
  output logic ct_a,
  output logic ct_b,
  output logic ct_vld,
  output logic done
);
  localparam int WIN  = 8;
  localparam int BLK  = 2 * WORD;
  localparam int CW   = $clog2(BLK);
  localparam int RW   = $clog2(ROUNDS);
  localparam logic [CW-1:0] LAST_BLK  = CW'(BLK - 1);
  localparam logic [CW-1:0] LAST_WORD = CW'(WORD - 1);
  localparam logic [RW-1:0] LAST_RND  = RW'(ROUNDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_OUT} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rnd;
  logic          odd;

  logic [1:0] din, kin, s1, s2, s8, xo, yo, andv, nb;

  assign odd = rnd[0];
  assign din = {pb_bit, pa_bit};
  assign kin = {kb_bit, ka_bit};

  always_comb begin
    andv[0] = (s1[0] & s8[0]) ^ rnd_bit;
    andv[1] = ((rnd_bit ^ (s1[0] & s8[1])) ^ (s1[1] & s8[0])) ^ (s1[1] & s8[1]);
    for (int s = 0; s < 2; s++)
      nb[s] = yo[s] ^ kin[s] ^ s2[s] ^ andv[s];
  end

  for (genvar g = 0; g < 2; g++) begin : g_share
    logic [WORD-1:0] xf, yf;
    logic [WIN-1:0]  ra, rb;
    logic [WIN-1:0]  win;

    assign win   = odd ? rb : ra;
    assign s1[g] = win[0];
    assign s2[g] = win[1];
    assign s8[g] = win[WIN-1];
    assign xo[g] = xf[0];
    assign yo[g] = yf[0];

    always_ff @(posedge clk) begin
      case (st)
        S_LOAD: begin
          xf <= {din[g], xf[WORD-1:1]};
          yf <= {xf[0], yf[WORD-1:1]};
          ra <= {ra[WIN-2:0], din[g]};
        end
        S_RUN: begin
          xf <= {nb[g], xf[WORD-1:1]};
          yf <= {xf[0], yf[WORD-1:1]};
          if (odd) begin
            rb <= {rb[WIN-2:0], xf[0]};
            ra <= {ra[WIN-2:0], nb[g]};
          end else begin
            ra <= {ra[WIN-2:0], xf[0]};
            rb <= {rb[WIN-2:0], nb[g]};
          end
        end
        S_OUT: begin
          xf <= {1'b0, xf[WORD-1:1]};
          yf <= {xf[0], yf[WORD-1:1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      rnd  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_LOAD;
          cnt <= '0;
          rnd <= '0;
        end
        S_LOAD: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BLK) begin
            st  <= S_RUN;
            cnt <= '0;
          end
        end
        S_RUN: begin
          if (cnt == LAST_WORD) begin
            cnt <= '0;
            if (rnd == LAST_RND) st <= S_OUT;
            else rnd <= rnd + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_OUT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BLK) begin
            st   <= S_IDLE;
            cnt  <= '0;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign key_take = (st == S_RUN);
  assign ct_vld   = (st == S_OUT);
  assign ct_a     = ct_vld & yo[0];
  assign ct_b     = ct_vld & yo[1];
endmodule

// File: rtl/masked_simon_serial_chk.sv
module masked_simon_serial_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic key_take,
  input logic ct_vld,
  input logic done
);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_take && ct_vld));

  assert_run_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_take |=> (key_take || ct_vld));

  assert_out_contiguous_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ct_vld |=> (ct_vld || done));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ct_vld));

  assert_start_busy_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (key_take || ct_vld)) |=> (key_take || ct_vld || done));
endmodule

bind masked_simon_serial masked_simon_serial_chk u_chk (.*);

// File: tb/masked_simon_serial_tb.sv
module masked_simon_serial_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pa_bit = 1'b0, pb_bit = 1'b0;
  logic ka_bit = 1'b0, kb_bit = 1'b0, rnd_bit = 1'b0;
  logic key_take, ct_a, ct_b, ct_vld, done;

  always #10 clk = ~clk;

  masked_simon_serial u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pa_bit(pa_bit), .pb_bit(pb_bit),
    .ka_bit(ka_bit), .kb_bit(kb_bit), .rnd_bit(rnd_bit),
    .key_take(key_take), .ct_a(ct_a), .ct_b(ct_b),
    .ct_vld(ct_vld), .done(done)
  );

  localparam int NV = 6;
  localparam logic [127:0] V_KEY [NV] = '{
    128'h0f0e0d0c0b0a09080706050403020100,
    128'h0f0e0d0c0b0a09080706050403020100,
    128'h0f0e0d0c0b0a09080706050403020100,
    128'h0,
    {128{1'b1}},
    128'h3c5a96e1f00fd2b47718a9c6e35b0d24};
  localparam logic [127:0] V_PT [NV] = '{
    128'h63736564207372656c6c657661727420,
    128'h63736564207372656c6c657661727420,
    128'h63736564207372656c6c657661727420,
    128'h0,
    128'h80000000000000000000000000000001,
    128'h9a17c04e5b2d6f8831e0a4c7d6b25f93};
  localparam logic [127:0] V_PM [NV] = '{
    128'h0,
    128'h0123456789abcdeffedcba9876543210,
    128'hd1e2f30415263748596a7b8c9daebfc0,
    {128{1'b1}},
    128'h5555aaaa3333cccc0f0ff0f000ffff00,
    128'h7e3a1b9c42d5f6089e71c3a5b4d2e6f1};
  localparam logic [63:0] V_KM [NV] = '{
    64'h0, 64'hb7e151628aed2a6a, 64'h243f6a8885a308d3,
    64'h1, 64'hf0f0f0f00f0f0f0f, 64'h9e3779b97f4a7c15};
  localparam logic [15:0] V_SEED [NV] = '{
    16'h0, 16'hace1, 16'h1d2b, 16'hffff, 16'h8001, 16'h5a5a};
  localparam logic [NV-1:0] V_POKE = 6'b100000;
  localparam logic [127:0] PUB_CT = 128'h49681b1e1e54fe3f65aa832af84e0bbc;

  int n_chk = 0, n_bad = 0;
  logic [63:0] rk_q [68];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rol(input logic [63:0] v, input int n);
    return (v << n) | (v >> (64 - n));
  endfunction

  task automatic expand(input logic [127:0] key);
    logic [63:0] z = 64'h7369f885192c0ef5;
    rk_q[0] = key[63:0];
    rk_q[1] = key[127:64];
    for (int i = 0; i < 66; i++)
      rk_q[i+2] = 64'hfffffffffffffffc ^ {63'b0, z[i % 62]} ^ rk_q[i] ^
                  rol(rk_q[i+1], 61) ^ rol(rk_q[i+1], 60);
  endtask

  function automatic logic [127:0] enc(input logic [127:0] pt);
    logic [63:0] x = pt[127:64], y = pt[63:0], t;
    for (int r = 0; r < 68; r++) begin
      t = x;
      x = y ^ (rol(x, 1) & rol(x, 8)) ^ rol(x, 2) ^ rk_q[r];
      y = t;
    end
    return {x, y};
  endfunction

  task automatic run_enc(input logic [127:0] pt, input logic [127:0] pm, input logic [63:0] km,
                         input logic [15:0] seed, input bit poke,
                         output logic [127:0] ca, output logic [127:0] cb,
                         output int nkey, output int nout, output bit done_ok);
    logic [15:0] lf = seed;
    logic [63:0] kmr;
    logic [127:0] pa = pt ^ pm;
    bit prev_vld = 1'b0;
    ca = '0; cb = '0; nkey = 0; nout = 0; done_ok = 1'b0;
    @(negedge clk);
    start = 1'b1;
    for (int j = 0; j < 128; j++) begin
      @(negedge clk);
      start = 1'b0;
      pa_bit = pa[j];
      pb_bit = pm[j];
    end
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        done_ok = prev_vld;
        break;
      end
      prev_vld = ct_vld;
      if (key_take) begin
        kmr = rol(km, (nkey / 64) % 64);
        ka_bit  = rk_q[nkey / 64][nkey % 64] ^ kmr[nkey % 64];
        kb_bit  = kmr[nkey % 64];
        rnd_bit = lf[0];
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        nkey++;
        if (poke && nkey == 1000) start = 1'b1;
      end
      if (ct_vld) begin
        if (nout < 128) begin
          ca[nout] = ct_a;
          cb[nout] = ct_b;
        end
        nout++;
        if (poke && nout == 5) start = 1'b1;
      end
    end
  endtask

  bit finished = 1'b0;

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] ca, cb, ref_ct;
    int nkey, nout;
    bit dok;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk({key_take, ct_vld, done} == 3'b000, "R1 outputs in reset", {key_take, ct_vld, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({key_take, ct_vld, done} == 3'b000, "R1 outputs after release", {key_take, ct_vld, done}, 0);

    for (int v = 0; v < NV; v++) begin
      expand(V_KEY[v]);
      ref_ct = enc(V_PT[v]);
      run_enc(V_PT[v], V_PM[v], V_KM[v], V_SEED[v], V_POKE[v], ca, cb, nkey, nout, dok);
      chk((ca ^ cb) === ref_ct, "R4 R3 recombined ciphertext", ca ^ cb, ref_ct);
      chk(nkey == 4352, "R2 key cycle count", nkey, 4352);
      chk(nout == 128, "R5 output cycle count", nout, 128);
      chk(dok, "R6 done right after last bit", dok, 1);
      if (v == 0) begin
        chk(ref_ct === PUB_CT, "R4 model published vector", ref_ct, PUB_CT);
        chk(ca === PUB_CT, "R8 unprotected share a", ca, PUB_CT);
        chk(cb === 128'h0, "R8 unprotected share b", cb, 0);
      end
      if (v == 1 || v == 2)
        chk((ca ^ cb) === PUB_CT, "R9 masked published vector", ca ^ cb, PUB_CT);
      if (V_POKE[v])
        chk((ca ^ cb) === ref_ct && nkey == 4352, "R7 start ignored while busy", ca ^ cb, ref_ct);
      if (v > 0)
        chk(dok && nkey == 4352, "R10 back-to-back start", nkey, 4352);
    end

    // R7 idle without start stays idle
    repeat (20) begin
      @(negedge clk);
      if (key_take || ct_vld || done) break;
    end
    chk({key_take, ct_vld, done} == 3'b000, "R7 idle holds without start", {key_take, ct_vld, done}, 0);

    // R10 reset mid-run, then a clean encryption
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (400) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({key_take, ct_vld, done} == 3'b000, "R1 quiet after mid-run reset", {key_take, ct_vld, done}, 0);
    expand(V_KEY[5]);
    ref_ct = enc(V_PT[5]);
    run_enc(V_PT[5], V_PM[2], V_KM[2], V_SEED[2], 1'b0, ca, cb, nkey, nout, dok);
    chk((ca ^ cb) === ref_ct, "R10 R9 result after reset", ca ^ cb, ref_ct);
    chk(nkey == 4352 && nout == 128 && dok, "R10 counts after reset", nkey, 4352);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule